// File: doc/BRIEF.md
# Hobby Servo Position Pulse Generator

This block drives one hobby servo. A counter clocked at 1 MHz runs freely, so one count is one microsecond. It wraps to zero by itself at a power-of-two boundary, and each wrap starts a new frame. The output pulse sits at the start of every frame. Its width is a fixed 1000 µs floor plus a position offset read from an input port, so the pulse spans 1 ms to 2 ms.

The frame-select input picks the frame length. A short frame is 16,384 counts and a long frame is 32,768 counts. The two lengths differ only in whether the top counter bit takes part in the wrap, so the counter needs no reload value. The position value and the frame select are captured only at the moment the counter returns to zero. A change on either input in the middle of a frame therefore cannot clip or stretch the pulse that is already in progress.

The block does not generate or divide its clock, and it drives a single channel.

Top module: `servo_pulse_gen`

## Requirements
- R1: The frame counter advances by exactly one on every clock edge outside reset. It returns to zero only by wrapping at its terminal count and is never loaded with any other value.
- R2: When the captured frame select is 1 (long), a frame lasts 32,768 clock cycles. When it is 0 (short), a frame lasts 16,384 cycles. The distance between consecutive rising edges of `pulse_o` equals the length of the frame between them.
- R3: The pulse lasts 1000 cycles plus the captured position value. A position of 0 gives the 1000-cycle minimum.
- R4: A position value of 500 gives a pulse of 1500 cycles, which is the servo centre position.
- R5: `pulse_o` is registered. It is high in the cycle after the counter holds a value below the captured width, so it rises one cycle after each wrap to zero and stays low for the rest of the frame.
- R6: A position value above 1000 acts as 1000, so the pulse never exceeds 2000 cycles. For example, 1001 and 1023 both give 2000 cycles.
- R7: Position and frame select are captured only on the cycle the counter wraps to zero, and also during reset. Changes between wraps have no effect on the current frame's pulse width or frame length.
- R8: A synchronous active-high reset clears the counter to zero and drives `pulse_o` low on the following edge. The inputs present during reset govern the first frame.
- R9: While the short frame is in force, the top counter bit stays at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz counting clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| frame_sel_i | input | 1 | Frame length select: 1 = 32,768 counts, 0 = 16,384 counts |
| position_i | input | 10 | Position offset in counts added to the 1000-count floor; values above 1000 are clamped |
| pulse_o | output | 1 | Registered servo pulse line |

## Verification
The assertions assume that reset, when applied, is held for at least two clock cycles. The pulse-length property assumes that the captured width stays below the shorter frame length. The clamp guarantees this for any position input, so any 10-bit value is legal.

The stimulus holds reset for three cycles at the start and for two near the end. It draws position values across the full 10-bit range, including values above the clamp point. It changes both inputs in the middle of every frame, both while the pulse is high and after it has ended, and sets the next frame's values well before the wrap.

// File: rtl/servo_pkg.sv
package servo_pkg;

  typedef enum logic {
    FRAME_SHORT = 1'b0,
    FRAME_LONG  = 1'b1
  } frame_e;

endpackage

// File: rtl/servo_frame_counter.sv
module servo_frame_counter
  import servo_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  frame_e           mode_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] TERM_LONG  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TERM_SHORT = {1'b0, {(CNT_W-1){1'b1}}};

  logic [CNT_W-1:0] term;

  always_comb begin
    term = (mode_q == FRAME_LONG) ? TERM_LONG : TERM_SHORT;
    wrap = (cnt_q == term);
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> cnt_q == $past(cnt_q) + 1'b1); // R1

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    wrap |=> cnt_q == '0); // R2

  AST_SHORT_HIGH_BIT: assert property (@(posedge clk) disable iff (rst)
    mode_q == FRAME_SHORT |-> !cnt_q[CNT_W-1]); // R9

endmodule

// File: rtl/servo_frame_latch.sv
module servo_frame_latch
  import servo_pkg::*;
#(
  parameter int POS_W   = 10,
  parameter int WID_W   = 15,
  parameter int MIN_W   = 1000,
  parameter int POS_MAX = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [POS_W-1:0] pos_i,
  input  frame_e           sel_i,
  output logic [WID_W-1:0] width_q,
  output frame_e           mode_q
);

  localparam logic [POS_W-1:0] POS_CAP = POS_W'(POS_MAX);
  localparam logic [WID_W-1:0] WID_MIN = WID_W'(MIN_W);
  localparam logic [WID_W-1:0] WID_TOP = WID_W'(MIN_W + POS_MAX);

  logic [POS_W-1:0] pos_c;
  logic [WID_W-1:0] width_d;

  always_comb begin
    pos_c   = (pos_i > POS_CAP) ? POS_CAP : pos_i;
    width_d = WID_MIN + WID_W'(pos_c);
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      width_q <= width_d;
      mode_q  <= sel_i;
    end
  end

  AST_HOLD_MIDFRAME: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(width_q) && $stable(mode_q)); // R7

  AST_WIDTH_RANGE: assert property (@(posedge clk) disable iff (rst)
    width_q >= WID_MIN && width_q <= WID_TOP); // R6

endmodule

// File: rtl/servo_pulse_out.sv
module servo_pulse_out #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] width_q,
  output logic             pulse_o
);

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= 1'b0;
    else     pulse_o <= (cnt_q < width_q);
  end

  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> cnt_q == CNT_W'(1)); // R5

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $fell(pulse_o) |-> cnt_q == width_q + 1'b1); // R3

endmodule

// File: rtl/servo_pulse_gen.sv
module servo_pulse_gen
  import servo_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int POS_W   = 10,
  parameter int MIN_W   = 1000,
  parameter int POS_MAX = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_sel_i,
  input  logic [POS_W-1:0] position_i,
  output logic             pulse_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] width_q;
  logic             wrap;
  frame_e           mode_q;
  frame_e           sel_e;

  assign sel_e = frame_e'(frame_sel_i);

  servo_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .mode_q (mode_q),
    .cnt_q  (cnt_q),
    .wrap   (wrap)
  );

  servo_frame_latch #(
    .POS_W  (POS_W),
    .WID_W  (CNT_W),
    .MIN_W  (MIN_W),
    .POS_MAX(POS_MAX)
  ) u_latch (
    .clk    (clk),
    .rst    (rst),
    .wrap   (wrap),
    .pos_i  (position_i),
    .sel_i  (sel_e),
    .width_q(width_q),
    .mode_q (mode_q)
  );

  servo_pulse_out #(.CNT_W(CNT_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .cnt_q  (cnt_q),
    .width_q(width_q),
    .pulse_o(pulse_o)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> cnt_q == '0 && !pulse_o); // R8

endmodule

// File: tb/tb_servo_pulse_gen.sv
module tb_servo_pulse_gen;

  logic       clk = 1'b0;
  logic       rst;
  logic       frame_sel_i;
  logic [9:0] position_i;
  logic       pulse_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  servo_pulse_gen dut (
    .clk        (clk),
    .rst        (rst),
    .frame_sel_i(frame_sel_i),
    .position_i (position_i),
    .pulse_o    (pulse_o)
  );

  // reference state, derived from the requirements
  int    m_cnt, m_width, m_len, m_pulse;
  bit    m_long;
  bit    frame_done;
  int    cyc = 0;
  int    rise_cyc = 0;
  bit    have_rise = 0;
  bit    measuring = 1;
  int    prev_len, active_w, pend_len, pend_w;
  string active_tag, pend_tag;
  bit    prev_pulse = 0;

  function automatic int exp_width(int raw);
    return 1000 + ((raw > 1000) ? 1000 : raw);
  endfunction

  function automatic int frame_len(bit lng);
    return lng ? 32768 : 16384;
  endfunction

  function automatic string width_tag(int raw);
    if (raw > 1000) return "R6";
    if (raw == 500) return "R4";
    if (raw == 0)   return "R3";
    return "R7";
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic capture();
    m_width  = exp_width(position_i);
    m_long   = frame_sel_i;
    pend_w   = m_width;
    pend_len = frame_len(m_long);
    pend_tag = width_tag(position_i);
  endtask

  // advance one clock, then compare at the falling edge
  task automatic step();
    frame_done = 0;
    if (rst) begin
      m_cnt = 0; m_pulse = 0; capture(); have_rise = 0;
    end else begin
      m_pulse = (m_cnt < m_width);
      if (m_cnt == frame_len(m_long) - 1) begin
        m_cnt = 0; capture(); frame_done = 1;
      end else m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    check(pulse_o === m_pulse[0], "R5", pulse_o, m_pulse);
    if (measuring && pulse_o && !prev_pulse) begin
      if (have_rise)
        check(cyc - rise_cyc == prev_len, "R2", cyc - rise_cyc, prev_len);
      have_rise  = 1;
      rise_cyc   = cyc;
      prev_len   = pend_len;
      active_w   = pend_w;
      active_tag = pend_tag;
    end
    if (measuring && !pulse_o && prev_pulse && have_rise)
      check(cyc - rise_cyc == active_w, active_tag, cyc - rise_cyc, active_w);
    prev_pulse = pulse_o;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pos_plan[7];
    bit mode_plan[7];
    void'($urandom(32'd2024));
    pos_plan  = '{500, 0, 1023, 0, 0, 1000, 1001};
    pos_plan[1] = $urandom_range(1, 999);
    pos_plan[4] = $urandom_range(1, 999);
    mode_plan = '{0, 0, 0, 0, 1, 1, 0};

    rst = 1'b1;
    position_i  = 10'(pos_plan[0]);
    frame_sel_i = mode_plan[0];
    repeat (3) step();
    check(pulse_o === 1'b0, "R8", pulse_o, 0);
    rst = 1'b0;

    for (int f = 0; f < 7; f++) begin
      do begin
        step();
        if (m_cnt == 700) begin
          position_i  = 10'($urandom_range(0, 1023));
          frame_sel_i = ~mode_plan[f];
        end
        if (m_cnt == 5000) begin
          position_i  = 10'(pos_plan[(f + 1) % 7]);
          frame_sel_i = mode_plan[(f + 1) % 7];
        end
      end while (!frame_done);
    end
    repeat (3) step();

    measuring = 0;
    rst = 1'b1;
    repeat (2) step();
    check(pulse_o === 1'b0, "R8", pulse_o, 0);
    rst = 1'b0;
    repeat (3) step();
    check(pulse_o === 1'b1, "R1", pulse_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule